// File: doc/BRIEF.md
# CAN Controller Operating-Mode and Bus-Off Sequencer

This block decides which operating mode a CAN controller is in: sleep, reset, operation or halt. Software asks for a mode through a two-bit request field and a separate sleep-request bit. The protocol engine reports what the node is doing on the bus: transmitting, receiving, frame completion, bus errors, lost arbitration, entry into bus-off, eleven-recessive-bit events and a dominant bus lock. The block grants a mode change at once or holds it until the current frame is finished. The choice depends on the node's role in that frame and on which mode was asked for.

The block also follows the bus-off condition from entry to recovery. Recovery is complete after a set number of eleven-recessive-bit events, or at once when forced recovery is asserted. A two-bit policy field sets how bus-off and halt interact. Halt can be entered as soon as bus-off begins, at the end of recovery, on a software request made during bus-off, or only after recovery when software has asked for halt.

Top module: `can_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is sleep. `mode_o` reads 2'b11 and `busoff_o` reads 0.
- R2: Sleep is left only at an edge where `sleep_req_i` is 0 and `mode_req_i` is 2'b00 (operation) or 2'b01 (reset). The mode becomes the requested one on that edge. A request of 2'b10 or 2'b11, or `sleep_req_i` at 1, keeps the block in sleep.
- R3: `mode_o` uses the request encoding: 2'b00 operation, 2'b01 reset, 2'b10 halt, 2'b11 sleep. With no frame in progress, a request is applied at the next edge. From reset or halt, `sleep_req_i` at 1 enters sleep. A request of 2'b11 outside sleep changes nothing.
- R4: In operation while receiving (`rx_active_i`=1, `tx_active_i`=0), a reset request is taken at the next edge. A halt request waits for the edge that samples `frame_end_i`.
- R5: In operation while transmitting (`tx_active_i`=1), both reset and halt requests are held until the edge that samples `frame_end_i` for the first frame to complete.
- R6: A held reset or halt request is applied at the edge that samples `bus_err_i` or `arb_lost_i`.
- R7: While `bus_locked_i` is 1, a software halt request is never granted. A reset request is still granted.
- R8: In operation, `busoff_enter_i` sets `busoff_o` when the policy is not 2'b01. `busoff_o` clears at the edge that samples the REC_EVENTS-th `rec11_i` pulse (128 by default). It also clears at the edge that samples `force_recov_i`.
- R9: With policy 2'b00, a halt request made during bus-off is granted only at the edge where recovery completes. A reset request during bus-off is granted at the next edge under every policy.
- R10: With policy 2'b01, `busoff_enter_i` in operation moves the block straight to halt, whether or not halt was requested.
- R11: With policy 2'b10, the block enters halt at the edge where bus-off recovery completes, whether or not halt was requested.
- R12: With policy 2'b11, a halt request during bus-off is granted at the next edge without waiting for recovery. Without a request, the block stays in operation when recovery completes.
- R13: `busoff_o` is 1 only in operation. Leaving operation clears the bus-off state and its event count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req_i | input | 2 | Requested mode (00 operation, 01 reset, 10 halt) |
| sleep_req_i | input | 1 | Sleep request |
| policy_i | input | 2 | Bus-off / halt interaction policy |
| force_recov_i | input | 1 | Forced bus-off recovery pulse |
| tx_active_i | input | 1 | Node is transmitting a frame |
| rx_active_i | input | 1 | Node is receiving a frame |
| frame_end_i | input | 1 | Current frame completed (pulse) |
| bus_err_i | input | 1 | Bus error detected (pulse) |
| arb_lost_i | input | 1 | Arbitration lost (pulse) |
| busoff_enter_i | input | 1 | Protocol engine entered bus-off (pulse) |
| rec11_i | input | 1 | Eleven consecutive recessive bits seen (pulse) |
| bus_locked_i | input | 1 | Bus held dominant |
| mode_o | output | 2 | Current mode (11 = sleep) |
| busoff_o | output | 1 | Bus-off state flag |

## Verification
The hardest situation to reach is the exact edge where bus-off recovery completes. Policies 2'b00 and 2'b10 turn into halt on that edge alone, and 2'b11 must not. The stimulus holds `rec11_i` high for REC_EVENTS-1 cycles and checks that the block is still in bus-off. It then supplies the last event and checks the mode on the following edge, once for each policy. The stimulus also uses forced recovery and a reset request arriving during bus-off, so that all three ways out of bus-off are covered.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OPER  = 2'b00,
        MODE_RESET = 2'b01,
        MODE_HALT  = 2'b10,
        MODE_SLEEP = 2'b11
    } can_mode_e;

    typedef enum logic [1:0] {
        BO_HALT_AFTER_REQ = 2'b00,
        BO_HALT_AT_ENTRY  = 2'b01,
        BO_HALT_AT_END    = 2'b10,
        BO_HALT_ON_REQ    = 2'b11
    } bo_policy_e;

    function automatic logic frame_released(input logic fend, input logic berr, input logic alost);
        return fend | berr | alost;
    endfunction

endpackage

// File: rtl/can_bo_tracker.sv
module can_bo_tracker #(
    parameter int REC_EVENTS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic clear,
    input  logic force_recov,
    input  logic rec11,
    output logic active,
    output logic done
);
    localparam int CW = (REC_EVENTS > 1) ? $clog2(REC_EVENTS) : 1;
    localparam logic [CW-1:0] LAST = CW'(REC_EVENTS - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;

    assign done   = active_q & (force_recov | (rec11 & (cnt_q == LAST)));
    assign active = active_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (done) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q && rec11) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_idle_count_R8: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> (cnt_q == '0));

endmodule

// File: rtl/can_req_gate.sv
module can_req_gate
    import can_mode_pkg::*;
(
    input  can_mode_e req,
    input  logic      tx_active,
    input  logic      rx_active,
    input  logic      frame_end,
    input  logic      bus_err,
    input  logic      arb_lost,
    input  logic      bus_locked,
    output logic      reset_go,
    output logic      halt_go
);
    logic rel;

    always_comb begin
        rel      = frame_released(frame_end, bus_err, arb_lost);
        reset_go = (req == MODE_RESET) && (!tx_active || rel);
        halt_go  = (req == MODE_HALT) && !bus_locked &&
                   (!(tx_active || rx_active) || rel);
    end

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  can_mode_e  req,
    input  logic       sleep_req,
    input  bo_policy_e policy,
    input  logic       busoff_enter,
    input  logic       bus_locked,
    input  logic       tx_active,
    input  logic       frame_rel,
    input  logic       reset_go,
    input  logic       halt_go,
    input  logic       bo_active,
    input  logic       bo_done,
    output can_mode_e  mode,
    output logic       bo_start,
    output logic       bo_clear
);
    can_mode_e state_q, nxt;
    logic      soft_halt_ok;

    always_comb begin
        nxt          = state_q;
        bo_start     = 1'b0;
        soft_halt_ok = (req == MODE_HALT) && !bus_locked;
        unique case (state_q)
            MODE_SLEEP: begin
                if (!sleep_req && (req == MODE_OPER || req == MODE_RESET))
                    nxt = req;
            end
            MODE_RESET, MODE_HALT: begin
                if (sleep_req)                 nxt = MODE_SLEEP;
                else if (req == MODE_OPER)     nxt = MODE_OPER;
                else if (req == MODE_RESET)    nxt = MODE_RESET;
                else if (soft_halt_ok)         nxt = MODE_HALT;
            end
            MODE_OPER: begin
                if (bo_active) begin
                    if (req == MODE_RESET) begin
                        nxt = MODE_RESET;
                    end else if (bo_done) begin
                        if (policy == BO_HALT_AT_END ||
                            (policy == BO_HALT_AFTER_REQ && soft_halt_ok))
                            nxt = MODE_HALT;
                    end else if (policy == BO_HALT_ON_REQ && soft_halt_ok) begin
                        nxt = MODE_HALT;
                    end
                end else if (busoff_enter) begin
                    if (policy == BO_HALT_AT_ENTRY) nxt = MODE_HALT;
                    else                            bo_start = 1'b1;
                end else if (reset_go) begin
                    nxt = MODE_RESET;
                end else if (halt_go) begin
                    nxt = MODE_HALT;
                end
            end
            default: nxt = MODE_SLEEP;
        endcase
        bo_clear = (nxt != MODE_OPER);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_SLEEP;
        else     state_q <= nxt;
    end

    assign mode = state_q;

    assert_sleep_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_SLEEP && sleep_req) |=> (state_q == MODE_SLEEP));

    assert_tx_defer_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_OPER && !bo_active && !busoff_enter && tx_active && !frame_rel)
        |=> (state_q == MODE_OPER));

    assert_lock_no_halt_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_RESET && bus_locked) |=> (state_q != MODE_HALT));

    assert_entry_halt_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_OPER && !bo_active && busoff_enter && policy == BO_HALT_AT_ENTRY)
        |=> (state_q == MODE_HALT));

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int REC_EVENTS = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_req_i,
    input  logic       sleep_req_i,
    input  logic [1:0] policy_i,
    input  logic       force_recov_i,
    input  logic       tx_active_i,
    input  logic       rx_active_i,
    input  logic       frame_end_i,
    input  logic       bus_err_i,
    input  logic       arb_lost_i,
    input  logic       busoff_enter_i,
    input  logic       rec11_i,
    input  logic       bus_locked_i,
    output logic [1:0] mode_o,
    output logic       busoff_o
);
    can_mode_e  req, mode;
    bo_policy_e policy;
    logic       reset_go, halt_go, bo_active, bo_done, bo_start, bo_clear, frame_rel;

    assign req       = can_mode_e'(mode_req_i);
    assign policy    = bo_policy_e'(policy_i);
    assign frame_rel = frame_released(frame_end_i, bus_err_i, arb_lost_i);

    can_req_gate u_gate (
        .req        (req),
        .tx_active  (tx_active_i),
        .rx_active  (rx_active_i),
        .frame_end  (frame_end_i),
        .bus_err    (bus_err_i),
        .arb_lost   (arb_lost_i),
        .bus_locked (bus_locked_i),
        .reset_go   (reset_go),
        .halt_go    (halt_go)
    );

    can_bo_tracker #(.REC_EVENTS(REC_EVENTS)) u_bo (
        .clk         (clk),
        .rst         (rst),
        .start       (bo_start),
        .clear       (bo_clear),
        .force_recov (force_recov_i),
        .rec11       (rec11_i),
        .active      (bo_active),
        .done        (bo_done)
    );

    can_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .sleep_req    (sleep_req_i),
        .policy       (policy),
        .busoff_enter (busoff_enter_i),
        .bus_locked   (bus_locked_i),
        .tx_active    (tx_active_i),
        .frame_rel    (frame_rel),
        .reset_go     (reset_go),
        .halt_go      (halt_go),
        .bo_active    (bo_active),
        .bo_done      (bo_done),
        .mode         (mode),
        .bo_start     (bo_start),
        .bo_clear     (bo_clear)
    );

    assign mode_o   = mode;
    assign busoff_o = bo_active;

    assert_busoff_only_oper_R13: assert property (@(posedge clk) disable iff (rst)
        busoff_o |-> (mode_o == 2'b00));

endmodule

// File: tb/can_mode_ctrl_bench.sv
`timescale 1ns/1ps
module can_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_req = 2'b01;
    logic       sleep_req = 1'b1;
    logic [1:0] policy = 2'b00;
    logic       force_recov = 0, tx_active = 0, rx_active = 0, frame_end = 0;
    logic       bus_err = 0, arb_lost = 0, busoff_enter = 0, rec11 = 0, bus_locked = 0;
    logic [1:0] mode_o;
    logic       busoff_o;

    int tests = 0, fails = 0;
    string tag = "R1";
    bit started = 0, finished = 0;

    always #10 clk = ~clk;

    can_mode_ctrl u_can_mode_ctrl (
        .clk(clk), .rst(rst), .mode_req_i(mode_req), .sleep_req_i(sleep_req),
        .policy_i(policy), .force_recov_i(force_recov), .tx_active_i(tx_active),
        .rx_active_i(rx_active), .frame_end_i(frame_end), .bus_err_i(bus_err),
        .arb_lost_i(arb_lost), .busoff_enter_i(busoff_enter), .rec11_i(rec11),
        .bus_locked_i(bus_locked), .mode_o(mode_o), .busoff_o(busoff_o)
    );

    // behavioural reference: modes as integers 0 oper, 1 reset, 2 halt, 3 sleep
    int m_mode = 3, m_cnt = 0;
    bit m_bo = 0;
    always @(posedge clk) begin
        int nm;
        bit fin, rel;
        started <= 1;
        if (rst) begin
            m_mode = 3; m_bo = 0; m_cnt = 0;
        end else begin
            nm  = m_mode;
            fin = 0;
            rel = frame_end || bus_err || arb_lost;
            if (m_bo) begin
                if (force_recov) fin = 1;
                else if (rec11 && m_cnt + 1 == 128) fin = 1;
            end
            if (m_mode == 3) begin
                if (!sleep_req && mode_req < 2) nm = mode_req;
            end else if (m_mode == 1 || m_mode == 2) begin
                if (sleep_req) nm = 3;
                else if (mode_req == 0) nm = 0;
                else if (mode_req == 1) nm = 1;
                else if (mode_req == 2 && !bus_locked) nm = 2;
            end else if (m_bo) begin
                if (mode_req == 1) nm = 1;
                else if (fin) begin
                    if (policy == 2 || (policy == 0 && mode_req == 2 && !bus_locked)) nm = 2;
                end else if (policy == 3 && mode_req == 2 && !bus_locked) nm = 2;
            end else if (busoff_enter) begin
                if (policy == 1) nm = 2;
            end else begin
                if (mode_req == 1 && (!tx_active || rel)) nm = 1;
                if (mode_req == 2 && !bus_locked && (!(tx_active || rx_active) || rel)) nm = 2;
            end
            if (nm != 0) begin m_bo = 0; m_cnt = 0; end
            else if (m_mode == 0 && !m_bo && busoff_enter && policy != 1) begin m_bo = 1; m_cnt = 0; end
            else if (fin) begin m_bo = 0; m_cnt = 0; end
            else if (m_bo && rec11) m_cnt++;
            m_mode = nm;
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            tests++;
            if (mode_o !== m_mode[1:0] || busoff_o !== m_bo) begin
                fails++;
                $display("FAIL %s per-cycle: mode=%0d exp %0d busoff=%0d exp %0d",
                         tag, mode_o, m_mode, busoff_o, m_bo);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic expect_state(input string r, input int em, input int eb);
        tests++;
        if (mode_o !== em[1:0] || busoff_o !== eb[0]) begin
            fails++;
            $display("FAIL %s: mode=%0d exp %0d busoff=%0d exp %0d", r, mode_o, em, busoff_o, eb);
        end
    endtask

    task automatic go_oper();
        mode_req = 0; sleep_req = 0; tx_active = 0; rx_active = 0; bus_locked = 0;
        cyc(1);
    endtask

    task automatic enter_busoff();
        busoff_enter = 1; cyc(1); busoff_enter = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        tag = "R1"; expect_state("R1", 3, 0);
        rst = 0;
        // R2: halt request does not wake, sleep_req holds
        tag = "R2"; mode_req = 2; sleep_req = 0; cyc(3); expect_state("R2", 3, 0);
        mode_req = 0; sleep_req = 1; cyc(3); expect_state("R2", 3, 0);
        mode_req = 1; sleep_req = 0; cyc(1); expect_state("R2", 1, 0);
        // R3 immediate application and encoding
        tag = "R3"; mode_req = 0; cyc(1); expect_state("R3", 0, 0);
        mode_req = 3; cyc(2); expect_state("R3", 0, 0);
        mode_req = 2; cyc(1); expect_state("R3", 2, 0);
        sleep_req = 1; cyc(1); expect_state("R3", 3, 0);
        go_oper(); expect_state("R3", 0, 0);
        // R4 receiver
        tag = "R4"; rx_active = 1; mode_req = 2; cyc(3); expect_state("R4", 0, 0);
        frame_end = 1; cyc(1); frame_end = 0; expect_state("R4", 2, 0);
        go_oper(); rx_active = 1; mode_req = 1; cyc(1); expect_state("R4", 1, 0);
        // R5 transmitter
        tag = "R5"; go_oper(); tx_active = 1; mode_req = 1; cyc(4); expect_state("R5", 0, 0);
        frame_end = 1; cyc(1); frame_end = 0; expect_state("R5", 1, 0);
        go_oper(); tx_active = 1; mode_req = 2; cyc(4); expect_state("R5", 0, 0);
        frame_end = 1; cyc(1); frame_end = 0; expect_state("R5", 2, 0);
        // R6 error / arbitration release
        tag = "R6"; go_oper(); tx_active = 1; mode_req = 1; cyc(2); expect_state("R6", 0, 0);
        bus_err = 1; cyc(1); bus_err = 0; expect_state("R6", 1, 0);
        go_oper(); tx_active = 1; mode_req = 2; cyc(2);
        arb_lost = 1; cyc(1); arb_lost = 0; expect_state("R6", 2, 0);
        // R7 bus lock
        tag = "R7"; go_oper(); bus_locked = 1; mode_req = 2; cyc(3); expect_state("R7", 0, 0);
        mode_req = 1; cyc(1); expect_state("R7", 1, 0);
        mode_req = 2; cyc(3); expect_state("R7", 1, 0);
        bus_locked = 0; cyc(1); expect_state("R7", 2, 0);
        // R8 recovery by count and by force, policy 00
        tag = "R8"; go_oper(); policy = 0; enter_busoff(); expect_state("R8", 0, 1);
        rec11 = 1; cyc(127); expect_state("R8", 0, 1);
        cyc(1); rec11 = 0; expect_state("R8", 0, 0);
        enter_busoff(); expect_state("R8", 0, 1);
        force_recov = 1; cyc(1); force_recov = 0; expect_state("R8", 0, 0);
        // R9 policy 00
        tag = "R9"; enter_busoff(); mode_req = 2; cyc(5); expect_state("R9", 0, 1);
        rec11 = 1; cyc(128); rec11 = 0; expect_state("R9", 2, 0);
        go_oper(); enter_busoff(); mode_req = 1; cyc(1); expect_state("R9", 1, 0);
        // R10 policy 01
        tag = "R10"; go_oper(); policy = 1; enter_busoff(); expect_state("R10", 2, 0);
        // R11 policy 10
        tag = "R11"; go_oper(); policy = 2; enter_busoff(); expect_state("R11", 0, 1);
        cyc(3); expect_state("R11", 0, 1);
        force_recov = 1; cyc(1); force_recov = 0; expect_state("R11", 2, 0);
        go_oper(); enter_busoff(); rec11 = 1; cyc(127); expect_state("R11", 0, 1);
        cyc(1); rec11 = 0; expect_state("R11", 2, 0);
        // R12 policy 11
        tag = "R12"; go_oper(); policy = 3; enter_busoff(); cyc(2); expect_state("R12", 0, 1);
        mode_req = 2; cyc(1); expect_state("R12", 2, 0);
        go_oper(); enter_busoff(); rec11 = 1; cyc(128); rec11 = 0; expect_state("R12", 0, 0);
        // R13 leaving operation clears count: partial count then reset, then fresh bus-off
        tag = "R13"; policy = 0; enter_busoff(); rec11 = 1; cyc(100); rec11 = 0;
        mode_req = 1; cyc(1); expect_state("R13", 1, 0);
        go_oper(); enter_busoff(); rec11 = 1; cyc(100); rec11 = 0; expect_state("R13", 0, 1);
        rec11 = 1; cyc(28); rec11 = 0; expect_state("R13", 0, 0);
        // R1 reset from a busy state
        tag = "R1"; enter_busoff(); rst = 1; cyc(1); expect_state("R1", 3, 0); rst = 0;
        cyc(2);
        finish_run();
    end
endmodule